// File: doc/BRIEF.md
# Three-Byte Serial LCD Framer

This block sits between a byte source and a character or graphics LCD controller that listens on a serial link. Each payload byte arrives on a valid/ready handshake. The block expands it into a 24-bit frame and shifts the frame out MSB first on a mode-0 serial clock and data pair. The frame has three parts in this order:

- a sync byte that carries the register-select state;
- the upper nibble of the payload;
- the lower nibble of the payload.

When the last bit has been sent, the block keeps the handshake closed for a fixed settle interval. This gives the controller time to finish its internal work before the next frame starts.

A separate address strobe latches the register-select flag, which chooses command or data. The latched value holds for every later byte until another address strobe changes it. A burst of bytes is therefore sent as back-to-back frames that all carry the same selection. The chip select is active high. It is raised and lowered only by explicit enable and disable request pulses.

Top module: `lcd_frame_tx`

## Requirements
- R1: After reset the block is ready (`byteReady`=1), the chip select is low, and the serial clock and data lines are both 0.
- R2: The sync byte, sent first, is 0xF8 when the latched register-select is 0 (command) and 0xFA when it is 1 (data). Reset selects command.
- R3: The second byte sent carries payload bits 7:4 in its bits 7:4, with its bits 3:0 zero.
- R4: The third byte sent carries payload bits 3:0 in its bits 7:4, with its bits 3:0 zero.
- R5: The serial clock runs at the system clock divided by `CLK_DIV` (default 4). Each bit is low for `CLK_DIV/2` cycles, then high for `CLK_DIV/2` cycles. Bits go out MSB first, and the data line is stable while the clock is high (mode 0). Exactly 24 rising edges are sent per frame.
- R6: After a byte is accepted, `byteReady` stays low for exactly `24*CLK_DIV + SETTLE_CYCLES` system clock cycles.
- R7: A pulse on `csEnReq` drives `csOut` to 1 on the next cycle. A pulse on `csDisReq` drives it to 0. If both are pulsed in the same cycle, disable wins.
- R8: An address strobe with `addrSel`=1 selects data mode, and one with `addrSel`=0 selects command mode. Every byte of a burst uses the value latched at the time the byte is accepted.
- R9: The serial clock is low whenever no frame is being shifted, which includes the settle interval and idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low synchronous reset |
| byteValid | input | 1 | Payload byte offered |
| byteData | input | 8 | Payload byte |
| byteReady | output | 1 | Block can accept a byte |
| addrValid | input | 1 | Latch register-select strobe |
| addrSel | input | 1 | Register-select value: 0 command, 1 data |
| csEnReq | input | 1 | Request chip select high |
| csDisReq | input | 1 | Request chip select low |
| sclk | output | 1 | Serial clock, idles low |
| sdo | output | 1 | Serial data, MSB first |
| csOut | output | 1 | Active-high chip select |

## Verification
The case that is hardest to reach from the ports is a frame whose nibble placement or sync value goes wrong for only some payloads. A shifter that swaps nibbles or drops a bit can still look correct for symmetric values such as 0x00, 0xFF or 0x55. The stimulus therefore sweeps all 256 payload values in command mode, then all 256 in data mode. It rebuilds every frame from the rising edges of the serial clock and compares it with the arithmetic expectation. The timing of the ready signal is measured on each of these frames. A final short burst after switching back to command mode shows that the latched selection is used by every byte of a burst.

// File: rtl/lcd_frame_pkg.sv
package lcdFramePkg;
  typedef enum logic [1:0] {
    ST_IDLE   = 2'd0,
    ST_SHIFT  = 2'd1,
    ST_SETTLE = 2'd2
  } stateT;

  // strobes from control to datapath
  typedef struct packed {
    logic load;   // capture a new payload into the frame register
    logic shift;  // advance the frame register by one bit
  } strobeT;

  localparam logic [7:0] SYNC_CMD = 8'hF8;
  localparam logic [7:0] SYNC_DAT = 8'hFA;
  localparam int FRAME_BITS = 24;
endpackage

// File: rtl/lcd_frame_ctrl.sv
module lcd_frame_ctrl
  import lcdFramePkg::*;
#(
  parameter int CLK_DIV       = 4,
  parameter int SETTLE_CYCLES = 10000
) (
  input  logic   clk,
  input  logic   rstN,
  input  logic   byteValid,
  output logic   byteReady,
  output logic   sclkOut,
  output strobeT strobe
);
  localparam int PH_W  = (CLK_DIV > 2) ? $clog2(CLK_DIV) : 1;
  localparam int BIT_W = $clog2(FRAME_BITS);
  localparam int SET_W = $clog2(SETTLE_CYCLES + 1);
  localparam logic [PH_W-1:0]  PH_LAST  = PH_W'(CLK_DIV - 1);
  localparam logic [PH_W-1:0]  PH_HALF  = PH_W'(CLK_DIV / 2);
  localparam logic [BIT_W-1:0] BIT_LAST = BIT_W'(FRAME_BITS - 1);
  localparam logic [SET_W-1:0] SET_LOAD = SET_W'(SETTLE_CYCLES);

  stateT             state;
  logic [PH_W-1:0]   phase;
  logic [BIT_W-1:0]  bitIdx;
  logic [SET_W-1:0]  settleCnt;
  logic              phaseEnd;

  assign byteReady    = (state == ST_IDLE);
  assign phaseEnd     = (state == ST_SHIFT) && (phase == PH_LAST);
  assign strobe.load  = byteValid && byteReady;
  assign strobe.shift = phaseEnd;
  assign sclkOut      = (state == ST_SHIFT) && (phase >= PH_HALF);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state     <= ST_IDLE;
      phase     <= '0;
      bitIdx    <= '0;
      settleCnt <= '0;
    end else begin
      case (state)
        ST_IDLE: begin
          if (strobe.load) begin
            state  <= ST_SHIFT;
            phase  <= '0;
            bitIdx <= '0;
          end
        end
        ST_SHIFT: begin
          if (phaseEnd) begin
            phase <= '0;
            if (bitIdx == BIT_LAST) begin
              state     <= ST_SETTLE;
              settleCnt <= SET_LOAD;
            end else begin
              bitIdx <= bitIdx + 1'b1;
            end
          end else begin
            phase <= phase + 1'b1;
          end
        end
        ST_SETTLE: begin
          if (settleCnt <= SET_W'(1)) state <= ST_IDLE;
          else settleCnt <= settleCnt - 1'b1;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/lcd_frame_dp.sv
module lcd_frame_dp
  import lcdFramePkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  strobeT     strobe,
  input  logic [7:0] byteData,
  input  logic       addrValid,
  input  logic       addrSel,
  input  logic       csEnReq,
  input  logic       csDisReq,
  output logic       sdo,
  output logic       csOut
);
  logic                  regSel;
  logic [FRAME_BITS-1:0] frameReg;
  logic [7:0]            syncByte;

  assign syncByte = regSel ? SYNC_DAT : SYNC_CMD;
  assign sdo      = frameReg[FRAME_BITS-1];

  always_ff @(posedge clk) begin
    if (!rstN) begin
      regSel   <= 1'b0;
      frameReg <= '0;
      csOut    <= 1'b0;
    end else begin
      if (addrValid) regSel <= addrSel;
      if (strobe.load)
        frameReg <= {syncByte, byteData[7:4], 4'h0, byteData[3:0], 4'h0};
      else if (strobe.shift)
        frameReg <= {frameReg[FRAME_BITS-2:0], 1'b0};
      if (csDisReq)     csOut <= 1'b0;
      else if (csEnReq) csOut <= 1'b1;
    end
  end
endmodule

// File: rtl/lcd_frame_tx.sv
module lcd_frame_tx
  import lcdFramePkg::*;
#(
  parameter int CLK_DIV       = 4,
  parameter int SETTLE_CYCLES = 10000
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       byteValid,
  input  logic [7:0] byteData,
  output logic       byteReady,
  input  logic       addrValid,
  input  logic       addrSel,
  input  logic       csEnReq,
  input  logic       csDisReq,
  output logic       sclk,
  output logic       sdo,
  output logic       csOut
);
  strobeT strobe;

  lcd_frame_ctrl #(.CLK_DIV(CLK_DIV), .SETTLE_CYCLES(SETTLE_CYCLES)) u_ctrl (
    .clk(clk), .rstN(rstN), .byteValid(byteValid),
    .byteReady(byteReady), .sclkOut(sclk), .strobe(strobe)
  );

  lcd_frame_dp u_dp (
    .clk(clk), .rstN(rstN), .strobe(strobe), .byteData(byteData),
    .addrValid(addrValid), .addrSel(addrSel),
    .csEnReq(csEnReq), .csDisReq(csDisReq),
    .sdo(sdo), .csOut(csOut)
  );
endmodule

// File: rtl/lcd_frame_chk.sv
module lcd_frame_chk (
  input logic clk,
  input logic rstN,
  input logic byteValid,
  input logic byteReady,
  input logic sclk,
  input logic sdo,
  input logic csEnReq,
  input logic csDisReq,
  input logic csOut
);
  // R5
  sdo_stable_high_chk: assert property (@(posedge clk) disable iff (!rstN)
    (sclk && $past(sclk)) |-> $stable(sdo));

  // R5
  sclk_high_min_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(sclk) |=> sclk);

  // R9
  sclk_idle_low_chk: assert property (@(posedge clk) disable iff (!rstN)
    byteReady |-> !sclk);

  // R7
  cs_enable_chk: assert property (@(posedge clk) disable iff (!rstN)
    (csEnReq && !csDisReq) |=> csOut);

  // R7
  cs_disable_chk: assert property (@(posedge clk) disable iff (!rstN)
    csDisReq |=> !csOut);

  // R6
  accept_busy_chk: assert property (@(posedge clk) disable iff (!rstN)
    (byteValid && byteReady) |=> !byteReady);
endmodule

bind lcd_frame_tx lcd_frame_chk u_frame_chk (
  .clk(clk), .rstN(rstN), .byteValid(byteValid), .byteReady(byteReady),
  .sclk(sclk), .sdo(sdo), .csEnReq(csEnReq), .csDisReq(csDisReq),
  .csOut(csOut)
);

// File: tb/test_lcd_frame_tx.sv
`timescale 1ns/1ps
module test_lcd_frame_tx;
  localparam int DIV    = 4;
  localparam int SETTLE = 20;
  localparam int BUSY   = 24 * DIV + SETTLE;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       byteValid = 1'b0;
  logic [7:0] byteData = 8'h00;
  logic       byteReady;
  logic       addrValid = 1'b0;
  logic       addrSel = 1'b0;
  logic       csEnReq = 1'b0;
  logic       csDisReq = 1'b0;
  logic       sclk, sdo, csOut;

  int checks = 0;
  int errors = 0;
  int totalBits = 0;
  logic [23:0] capReg = '0;

  always #2 clk = ~clk;

  lcd_frame_tx #(.CLK_DIV(DIV), .SETTLE_CYCLES(SETTLE)) i_lcd_frame_tx (
    .clk(clk), .rstN(rstN), .byteValid(byteValid), .byteData(byteData),
    .byteReady(byteReady), .addrValid(addrValid), .addrSel(addrSel),
    .csEnReq(csEnReq), .csDisReq(csDisReq),
    .sclk(sclk), .sdo(sdo), .csOut(csOut)
  );

  // receiver model: mode 0, sample on rising serial clock
  always @(posedge sclk) begin
    capReg    = {capReg[22:0], sdo};
    totalBits = totalBits + 1;
  end

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic setAddr(input logic v);
    @(negedge clk);
    addrValid = 1'b1; addrSel = v;
    @(negedge clk);
    addrValid = 1'b0;
  endtask

  // send one byte; check busy length, frame content and bit count
  task automatic sendByte(input logic [7:0] b, input logic isData);
    int startBits;
    int busy;
    logic [23:0] expFrame;
    @(negedge clk);
    while (!byteReady) @(negedge clk);
    startBits = totalBits;
    byteValid = 1'b1; byteData = b;
    @(negedge clk);
    byteValid = 1'b0;
    busy = 0;
    while (!byteReady) begin busy++; @(negedge clk); end
    // R6 busy interval
    check("R6 busy", busy, BUSY);
    // R2 R3 R4 frame layout
    expFrame = {(isData ? 8'hFA : 8'hF8), b[7:4], 4'h0, b[3:0], 4'h0};
    check(isData ? "R2/R3/R4 data frame (R8)" : "R2/R3/R4 cmd frame", capReg, expFrame);
    // R5 edge count
    check("R5 bits", totalBits - startBits, 24);
    // R9 idle low
    check("R9 idle sclk", sclk, 0);
  endtask

  initial begin
    repeat (200000 - 100) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // R1 reset state
    check("R1 ready", byteReady, 1);
    check("R1 cs", csOut, 0);
    check("R1 sclk", sclk, 0);
    check("R1 sdo", sdo, 0);

    // R7 chip select
    csEnReq = 1'b1; @(negedge clk); csEnReq = 1'b0;
    check("R7 enable", csOut, 1);
    csEnReq = 1'b1; csDisReq = 1'b1; @(negedge clk);
    csEnReq = 1'b0; csDisReq = 1'b0;
    check("R7 both disable wins", csOut, 0);
    csEnReq = 1'b1; @(negedge clk); csEnReq = 1'b0;
    check("R7 re-enable", csOut, 1);

    // R2 default command, full sweep
    for (int v = 0; v < 256; v++) sendByte(8'(v), 1'b0);

    // R8 data mode burst sweep
    setAddr(1'b1);
    for (int v = 0; v < 256; v++) sendByte(8'(255 - v), 1'b1);

    // R8 back to command mode
    setAddr(1'b0);
    for (int v = 0; v < 4; v++) sendByte(8'(8'h3C + v * 8'h11), 1'b0);

    csDisReq = 1'b1; @(negedge clk); csDisReq = 1'b0;
    check("R7 disable", csOut, 0);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule